// File: doc/BRIEF.md
# Interleaved Second-Channel DRAM Access Sequencer

This block lets a slow secondary client share a burst-8 DRAM with a faster primary client. It runs on the fast memory clock and divides it into a ten-cycle frame. Once per frame, at a phase position set by a parameter, it raises a one-cycle enable for the slow client. This places the secondary channel's command window at a different position of the frame than the primary channel's.

On each enable the block latches the client's 16-bit word address, write data and read/write flag. It then drives a two-step command sequence to the PHY. The first step is a row activate on command slot 3, with address bits 15:10 as the row. The second step is a column read or write. The column address is bits 9:3 followed by a rotated burst offset. For a write, the data is replicated over all eight beats. During the column step a channel-select output marks that this channel owns the bus. The byte mask unmasks only the beat that the owning channel's address selects.

The block also picks one fixed beat out of the 128-bit deserialized read word at count 7 of the frame. It holds that 16-bit value for the slow client until the next capture.

Top module: `dram_slot_seq`

## Requirements
- R1: `cli_en` is high for exactly one fast cycle in every ten: the cycle whose frame count equals `PHASE` (default 3). The frame count starts at 0 after reset and wraps from 9 to 0.
- R2: On the clock edge where `cli_en` is high, the block latches the client request. It then presents, for one cycle, `phy_cmd`=1 (activate) and `phy_slot`=3, with `phy_addr` equal to `cli_addr[15:10]` zero-extended to 15 bits.
- R3: In the cycle after the activate, the block presents the column step. `phy_cmd` is 3 for a write and 2 for a read. `phy_slot` is binary 10 followed by the write flag (101 write, 100 read). `phy_addr` is {5'b0, addr[9:3], off}, where off is 7 when addr[2:0]=0 and addr[2:0]-1 otherwise.
- R4: During a write column step, `phy_wdata` holds the 16-bit client data repeated eight times. In that cycle `phy_dq_oe` is 4'hF for a write and 4'h0 for a read.
- R5: `chan_sel` is 1 in the column-step cycle only, and 0 in every other cycle.
- R6: `phy_dm` is registered with `chan_sel`. Its value is ~(1<<k), where k is the latched client address bits 2:0 when `chan_sel` is 1, and `prim_lo` otherwise.
- R7: On the edge where the frame count is 7 (four cycles after `cli_en`), `cli_rdata` loads {`phy_rdword[103:96]`, `phy_rdword[39:32]`}. It holds that value unchanged on every other edge.
- R8: While `rst_n` is low, the outputs take these values at once, without waiting for a clock: `phy_cmd`=0, `phy_slot`=0, `phy_dq_oe`=0, `phy_dm`=8'hFF, `chan_sel`=0, `cli_rdata`=0, `cli_en`=0. Release of reset takes effect synchronously.
- R9: After the column step, the block returns to idle. From then until the next activate, `phy_cmd`=0 (no operation), `phy_slot`=0 and `phy_dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prim_lo | input | 3 | Primary channel's low address bits, used for the mask when this channel does not own the bus |
| cli_addr | input | 16 | Slow client word address |
| cli_wdata | input | 16 | Slow client write data |
| cli_write | input | 1 | 1 = write, 0 = read |
| phy_rdword | input | 128 | Deserialized read burst: low bytes in 63:0, high bytes in 127:64 |
| cli_en | output | 1 | One-of-ten enable for the slow client |
| cli_rdata | output | 16 | Held read result |
| phy_cmd | output | 2 | Command code: 0 no operation, 1 activate, 2 read, 3 write |
| phy_slot | output | 3 | Command-slot select |
| phy_addr | output | 15 | Row or column address field |
| phy_wdata | output | 128 | Write burst data |
| phy_dm | output | 8 | Byte mask per beat, active high (1 = masked) |
| phy_dq_oe | output | 4 | Data-line tristate enable |
| chan_sel | output | 1 | High while this channel owns the bus |

## Verification
The hardest case to reach is the read capture. It happens on one count out of ten, while the deserialized word changes every fast cycle. The bench drives a different, byte-distinct word on every cycle of a frame. It confirms that only the word present at count 7 is captured, and that the value stays put for the next nine cycles. The boundary offsets (low bits 0 and 7) and the mask hand-over between the primary and client low bits are reached from table rows whose `prim_lo` differs from the client's low bits. A reset is also dropped in the middle of a write column step, to show the asynchronous clear.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_COL  = 1'b1
  } seq_state_e;

  localparam logic [2:0] ACT_SLOT = 3'd3;
endpackage

// File: rtl/dss_phase_ctr.sv
module dss_phase_ctr #(
  parameter int SLOTS = 10,
  parameter int PHASE = 3,
  localparam int CNT_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             slot_en
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (cnt == CNT_W'(SLOTS - 1)) cnt_d = '0;
    else                          cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign slot_en = (cnt == CNT_W'(PHASE)) && rst_n;
endmodule

// File: rtl/dss_addr_map.sv
module dss_addr_map #(
  parameter int ADDR_W     = 16,
  parameter int PHY_ADDR_W = 15,
  parameter int ROW_LSB    = 10,
  parameter int BEAT_W     = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [PHY_ADDR_W-1:0] row_field,
  output logic [PHY_ADDR_W-1:0] col_field,
  output logic [BEAT_W-1:0]     beat
);
  logic [BEAT_W-1:0] burst_off;

  assign beat      = addr[BEAT_W-1:0];
  // Rotate down by one: 0 wraps to the top beat.
  assign burst_off = beat - 1'b1;
  assign row_field = PHY_ADDR_W'(addr[ADDR_W-1:ROW_LSB]);
  assign col_field = PHY_ADDR_W'({addr[ROW_LSB-1:BEAT_W], burst_off});
endmodule

// File: rtl/dss_beat_mask.sv
module dss_beat_mask #(
  parameter int BEATS = 8,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              own,
  input  logic [BEAT_W-1:0] prim_beat,
  input  logic [BEAT_W-1:0] cli_beat,
  output logic [BEATS-1:0]  mask
);
  logic [BEAT_W-1:0] k;

  assign k = own ? cli_beat : prim_beat;

  for (genvar i = 0; i < BEATS; i++) begin : g_beat
    assign mask[i] = (k != BEAT_W'(i));
  end
endmodule

// File: rtl/dss_capture.sv
module dss_capture #(
  parameter int DATA_W   = 16,
  parameter int BEATS    = 8,
  parameter int CAP_BEAT = 4,
  localparam int BYTE_W  = DATA_W / 2,
  localparam int WORD_W  = DATA_W * BEATS,
  localparam int LO_POS  = CAP_BEAT * BYTE_W,
  localparam int HI_POS  = BYTE_W * BEATS + CAP_BEAT * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (take) q_d = {word[HI_POS +: BYTE_W], word[LO_POS +: BYTE_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
  import dss_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int BEATS      = 8,
  parameter int SLOTS      = 10,
  parameter int PHASE      = 3,
  parameter int CAP_COUNT  = 7,
  parameter int CAP_BEAT   = 4,
  parameter int PHY_ADDR_W = 15,
  parameter int ROW_LSB    = 10,
  parameter int OE_W       = 4,
  localparam int BEAT_W    = $clog2(BEATS),
  localparam int CNT_W     = $clog2(SLOTS),
  localparam int WORD_W    = DATA_W * BEATS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BEAT_W-1:0]     prim_lo,
  input  logic [ADDR_W-1:0]     cli_addr,
  input  logic [DATA_W-1:0]     cli_wdata,
  input  logic                  cli_write,
  input  logic [WORD_W-1:0]     phy_rdword,
  output logic                  cli_en,
  output logic [DATA_W-1:0]     cli_rdata,
  output logic [1:0]            phy_cmd,
  output logic [2:0]            phy_slot,
  output logic [PHY_ADDR_W-1:0] phy_addr,
  output logic [WORD_W-1:0]     phy_wdata,
  output logic [BEATS-1:0]      phy_dm,
  output logic [OE_W-1:0]       phy_dq_oe,
  output logic                  chan_sel
);
  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Frame counter and client enable.
  logic [CNT_W-1:0] cnt_q;
  logic             slot_en;

  dss_phase_ctr #(.SLOTS(SLOTS), .PHASE(PHASE)) u_ctr (
    .clk(clk), .rst_n(rst_q), .cnt(cnt_q), .slot_en(slot_en)
  );
  assign cli_en = slot_en;

  // Latched request.
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q, req_addr_d;
  logic [DATA_W-1:0] req_data_q, req_data_d;
  logic              req_wr_q, req_wr_d;

  // Address decode on the live address while idle, latched otherwise.
  logic [ADDR_W-1:0]     map_in;
  logic [PHY_ADDR_W-1:0] row_field, col_field;
  logic [BEAT_W-1:0]     req_beat;

  assign map_in = (state_q == ST_IDLE) ? cli_addr : req_addr_q;

  dss_addr_map #(
    .ADDR_W(ADDR_W), .PHY_ADDR_W(PHY_ADDR_W), .ROW_LSB(ROW_LSB), .BEAT_W(BEAT_W)
  ) u_map (
    .addr(map_in), .row_field(row_field), .col_field(col_field), .beat(req_beat)
  );

  // Next-state values of the PHY outputs.
  cmd_e                  cmd_d;
  logic [2:0]            slot_d;
  logic [PHY_ADDR_W-1:0] addr_d;
  logic [WORD_W-1:0]     wdata_d;
  logic [OE_W-1:0]       oe_d;
  logic                  sel_d;
  logic [BEATS-1:0]      dm_d;

  always_comb begin
    state_d    = state_q;
    req_addr_d = req_addr_q;
    req_data_d = req_data_q;
    req_wr_d   = req_wr_q;
    cmd_d      = CMD_NOP;
    slot_d     = 3'd0;
    addr_d     = '0;
    wdata_d    = phy_wdata;
    oe_d       = '0;
    sel_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (slot_en) begin
          req_addr_d = cli_addr;
          req_data_d = cli_wdata;
          req_wr_d   = cli_write;
          cmd_d      = CMD_ACT;
          slot_d     = ACT_SLOT;
          addr_d     = row_field;
          state_d    = ST_COL;
        end
      end
      ST_COL: begin
        cmd_d   = req_wr_q ? CMD_WR : CMD_RD;
        slot_d  = {2'b10, req_wr_q};
        addr_d  = col_field;
        sel_d   = 1'b1;
        oe_d    = req_wr_q ? '1 : '0;
        if (req_wr_q) wdata_d = {BEATS{req_data_q}};
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  dss_beat_mask #(.BEATS(BEATS)) u_mask (
    .own(sel_d), .prim_beat(prim_lo), .cli_beat(req_beat), .mask(dm_d)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q    <= ST_IDLE;
      req_addr_q <= '0;
      req_data_q <= '0;
      req_wr_q   <= 1'b0;
      phy_cmd    <= CMD_NOP;
      phy_slot   <= 3'd0;
      phy_addr   <= '0;
      phy_wdata  <= '0;
      phy_dq_oe  <= '0;
      chan_sel   <= 1'b0;
      phy_dm     <= '1;
    end else begin
      state_q    <= state_d;
      req_addr_q <= req_addr_d;
      req_data_q <= req_data_d;
      req_wr_q   <= req_wr_d;
      phy_cmd    <= cmd_d;
      phy_slot   <= slot_d;
      phy_addr   <= addr_d;
      phy_wdata  <= wdata_d;
      phy_dq_oe  <= oe_d;
      chan_sel   <= sel_d;
      phy_dm     <= dm_d;
    end
  end

  // Read capture at a fixed frame count.
  logic cap_take;
  assign cap_take = (cnt_q == CNT_W'(CAP_COUNT));

  dss_capture #(.DATA_W(DATA_W), .BEATS(BEATS), .CAP_BEAT(CAP_BEAT)) u_cap (
    .clk(clk), .rst_n(rst_q), .take(cap_take), .word(phy_rdword), .q(cli_rdata)
  );
endmodule

// File: rtl/dram_slot_seq_chk.sv
module dram_slot_seq_chk
  import dss_pkg::*;
#(
  parameter int BEATS     = 8,
  parameter int CNT_W     = 4,
  parameter int CAP_COUNT = 7,
  parameter int DATA_W    = 16,
  parameter int OE_W      = 4
) (
  input logic              clk,
  input logic              rst_q,
  input logic              cli_en,
  input logic              chan_sel,
  input logic [1:0]        cmd,
  input logic [2:0]        slot,
  input logic [BEATS-1:0]  dm,
  input logic [OE_W-1:0]   oe,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  cnt
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    cli_en |=> !cli_en);

  a_r2_act_slot: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd == CMD_ACT) |-> (slot == ACT_SLOT));

  a_r2_act_then_col: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd == CMD_ACT) |=> (cmd == CMD_RD || cmd == CMD_WR));

  a_r3_col_slot: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd == CMD_RD || cmd == CMD_WR) |-> (slot == {2'b10, cmd == CMD_WR}));

  a_r4_oe_dir: assert property (@(posedge clk) disable iff (!rst_q)
    oe == ((cmd == CMD_WR) ? {OE_W{1'b1}} : {OE_W{1'b0}}));

  a_r5_sel_col: assert property (@(posedge clk) disable iff (!rst_q)
    chan_sel == (cmd == CMD_RD || cmd == CMD_WR));

  a_r6_mask_onehot: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(~dm) <= 1);

  a_r6_mask_owned: assert property (@(posedge clk) disable iff (!rst_q)
    chan_sel |-> ($countones(~dm) == 1));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (cnt != CNT_W'(CAP_COUNT)) |=> $stable(rdata));

  a_r9_back_idle: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd == CMD_RD || cmd == CMD_WR) |=> (cmd == CMD_NOP));
endmodule

bind dram_slot_seq dram_slot_seq_chk #(
  .BEATS(BEATS), .CNT_W(CNT_W), .CAP_COUNT(CAP_COUNT), .DATA_W(DATA_W), .OE_W(OE_W)
) u_chk (
  .clk(clk), .rst_q(rst_q), .cli_en(cli_en), .chan_sel(chan_sel),
  .cmd(phy_cmd), .slot(phy_slot), .dm(phy_dm), .oe(phy_dq_oe),
  .rdata(cli_rdata), .cnt(cnt_q)
);

// File: tb/dram_slot_seq_test.sv
module dram_slot_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   prim_lo = 3'd0;
  logic [15:0]  cli_addr = 16'd0;
  logic [15:0]  cli_wdata = 16'd0;
  logic         cli_write = 1'b0;
  logic [127:0] phy_rdword = '0;
  logic         cli_en;
  logic [15:0]  cli_rdata;
  logic [1:0]   phy_cmd;
  logic [2:0]   phy_slot;
  logic [14:0]  phy_addr;
  logic [127:0] phy_wdata;
  logic [7:0]   phy_dm;
  logic [3:0]   phy_dq_oe;
  logic         chan_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_slot_seq uut (
    .clk(clk), .rst_n(rst_n), .prim_lo(prim_lo), .cli_addr(cli_addr),
    .cli_wdata(cli_wdata), .cli_write(cli_write), .phy_rdword(phy_rdword),
    .cli_en(cli_en), .cli_rdata(cli_rdata), .phy_cmd(phy_cmd), .phy_slot(phy_slot),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_dm(phy_dm),
    .phy_dq_oe(phy_dq_oe), .chan_sel(chan_sel)
  );

  // {write, prim_lo, addr, data}
  localparam logic [35:0] VECS [6] = '{
    {1'b1, 3'd2, 16'h0000, 16'hA5C3},
    {1'b0, 3'd5, 16'hFFFF, 16'h1234},
    {1'b1, 3'd0, 16'h8A4D, 16'h0F0F},
    {1'b0, 3'd7, 16'h0409, 16'hBEEF},
    {1'b1, 3'd3, 16'hFC02, 16'h7E81},
    {1'b0, 3'd1, 16'h5556, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_row(input logic [15:0] a);
    return {9'd0, a[15:10]};
  endfunction

  function automatic logic [14:0] exp_col(input logic [15:0] a);
    logic [2:0] off;
    off = (a[2:0] == 3'd0) ? 3'd7 : a[2:0] - 3'd1;
    return {5'd0, a[9:3], off};
  endfunction

  function automatic logic [7:0] exp_dm(input logic [2:0] k);
    logic [7:0] m;
    m = 8'hFF;
    m[k] = 1'b0;
    return m;
  endfunction

  function automatic logic [127:0] rd_pat(input int i);
    logic [127:0] w;
    for (int b = 0; b < 16; b++) w[b*8 +: 8] = 8'(i * 16 + b);
    return w;
  endfunction

  function automatic logic [15:0] rd_exp(input int i);
    return {8'(i * 16 + 12), 8'(i * 16 + 4)};
  endfunction

  task automatic wait_en();
    for (int n = 0; n < 30; n++) begin
      @(negedge clk);
      if (cli_en) return;
    end
    chk(1'b0, "R1 enable missing", 128'(cli_en), 128'd1);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(phy_cmd == 2'd0 && phy_slot == 3'd0, "R8 cmd/slot in reset", 128'({phy_cmd, phy_slot}), 128'd0);
    chk(phy_dm == 8'hFF, "R8 mask in reset", 128'(phy_dm), 128'hFF);
    chk(phy_dq_oe == 4'd0 && !chan_sel && !cli_en, "R8 oe/sel/en in reset",
        128'({phy_dq_oe, chan_sel, cli_en}), 128'd0);
    chk(cli_rdata == 16'd0, "R8 rdata in reset", 128'(cli_rdata), 128'd0);
    rst_n = 1'b1;

    // R1: period of ten cycles
    wait_en();
    begin
      int gap;
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!cli_en && gap < 30);
      chk(gap == 10, "R1 enable period", 128'(gap), 128'd10);
      @(negedge clk);
      chk(!cli_en, "R1 enable one cycle", 128'(cli_en), 128'd0);
    end

    // Table of requests
    for (int v = 0; v < 6; v++) begin
      logic        w;
      logic [2:0]  p;
      logic [15:0] a, d;
      {w, p, a, d} = VECS[v];
      wait_en();
      cli_write = w; prim_lo = p; cli_addr = a; cli_wdata = d;
      @(negedge clk);
      chk(phy_cmd == 2'd1 && phy_slot == 3'd3, "R2 activate cmd/slot",
          128'({phy_cmd, phy_slot}), 128'({2'd1, 3'd3}));
      chk(phy_addr == exp_row(a), "R2 row address", 128'(phy_addr), 128'(exp_row(a)));
      chk(!chan_sel && phy_dm == exp_dm(p), "R6 primary mask in activate",
          128'({chan_sel, phy_dm}), 128'({1'b0, exp_dm(p)}));
      cli_addr = ~a; cli_write = ~w;
      @(negedge clk);
      chk(phy_cmd == (w ? 2'd3 : 2'd2) && phy_slot == {2'b10, w}, "R3 column cmd/slot",
          128'({phy_cmd, phy_slot}), 128'({(w ? 2'd3 : 2'd2), 2'b10, w}));
      chk(phy_addr == exp_col(a), "R3 column address", 128'(phy_addr), 128'(exp_col(a)));
      chk(phy_dq_oe == (w ? 4'hF : 4'h0), "R4 tristate enable", 128'(phy_dq_oe),
          128'(w ? 4'hF : 4'h0));
      if (w) chk(phy_wdata == {8{d}}, "R4 replicated write data", phy_wdata, {8{d}});
      chk(chan_sel, "R5 channel select in column", 128'(chan_sel), 128'd1);
      chk(phy_dm == exp_dm(a[2:0]), "R6 client mask", 128'(phy_dm), 128'(exp_dm(a[2:0])));
      @(negedge clk);
      chk(phy_cmd == 2'd0 && phy_slot == 3'd0 && phy_dq_oe == 4'd0, "R9 idle after column",
          128'({phy_cmd, phy_slot, phy_dq_oe}), 128'd0);
      chk(!chan_sel && phy_dm == exp_dm(p), "R5 select released, R6 primary mask",
          128'({chan_sel, phy_dm}), 128'({1'b0, exp_dm(p)}));
    end

    // R7: capture only at count 7, hold for the rest of the frame
    wait_en();
    for (int s = 1; s <= 15; s++) begin
      @(negedge clk);
      if (s >= 5) begin
        logic [15:0] e;
        e = (s <= 14) ? rd_exp(4) : rd_exp(14);
        chk(cli_rdata == e, "R7 captured read value", 128'(cli_rdata), 128'(e));
      end
      phy_rdword = rd_pat(s);
    end

    // R8: asynchronous reset in a write column step
    wait_en();
    cli_write = 1'b1; cli_addr = 16'h1233; cli_wdata = 16'h5A5A; prim_lo = 3'd6;
    @(negedge clk);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk(phy_dq_oe == 4'd0 && !chan_sel && phy_cmd == 2'd0, "R8 async clear of column",
        128'({phy_dq_oe, chan_sel, phy_cmd}), 128'd0);
    chk(phy_dm == 8'hFF && cli_rdata == 16'd0, "R8 async clear of mask/rdata",
        128'({phy_dm, cli_rdata}), 128'({8'hFF, 16'd0}));
    @(negedge clk);
    rst_n = 1'b1;
    wait_en();
    cli_write = 1'b0; cli_addr = 16'h0C01; prim_lo = 3'd4;
    @(negedge clk);
    chk(phy_cmd == 2'd1 && phy_addr == exp_row(16'h0C01), "R2 activate after reset",
        128'({phy_cmd, phy_addr}), 128'({2'd1, exp_row(16'h0C01)}));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule